// File: doc/BRIEF.md
# Special-Register Access Unit

This block sits between a processor core's move-to-special-register and move-from-special-register instructions and a 16-bit special-register address space. A write presents an address, a 32-bit value and a strobe. The unit stores the value where the register is kept locally. It also applies the side effect that belongs to that register. Examples are a cache command pulse, a redirect of the fetch unit, an interrupt-enable notification, or filtering of the written bits. A separate combinational read port returns either stored contents or live state from the core.

Only registers with behaviour are kept in the unit. These are the status word, the interrupt mask and status words, the flush marker and one TLB set of match and translate entries. The general-purpose register file stays in the core and is reached through an alias window. The timer and the program counter are also outside the block and arrive as inputs. All side-effect outputs are registered and stay high for one clock after the edge that took the write.

Top module: `spr_access_unit`

## Requirements
- R1: A read at 0x0400..0x041F drives `gpr_rd_idx` with the address minus 0x0400 and returns `gpr_rd_data` on `rd_data`. Address 0x0420 is outside the window and reads as 0.
- R2: A write at 0x0400..0x041F raises `gpr_wr` for exactly the next cycle, with `gpr_wr_idx` set to address minus 0x0400 and `gpr_wr_data` set to the value. A write at 0x0420 raises no `gpr_wr`.
- R3: A write to the next-PC register (0x0010) raises `pc_load` for one cycle. `pc_load` also tells the fetch unit to drop any pending delay-slot branch. During that cycle `pc_load_val` holds the value and `pc_next_fetch` holds the value plus 4.
- R4: A read of 0x0010 returns the `cur_pc` input and not the written value. A read of the timer count at 0x5001 returns `timer_cnt`.
- R5: The status register (0x0011) reads 0x00008000 after reset. Every write stores the value with bit 15 forced to 1.
- R6: A status write that takes bit 2 (interrupt enable) from 0 to 1 raises `irq_en_pulse` for one cycle. A write that finds bit 2 already set raises no pulse.
- R7: A write to the interrupt mask (0x4800) stores the value. It raises `irq_en_pulse` exactly when status bit 2 is set.
- R8: A write to the interrupt status register (0x4802) is stored when `pic_level_mode` is 0. It is discarded, keeping the old value, when `pic_level_mode` is 1. The reset value is 0.
- R9: A write to a cache command register raises `cmd_valid` for one cycle, with `cmd_addr` set to the value and the following `cmd_op` codes: 0x3002 gives 1 (data prefetch), 0x3003 gives 2 (data flush), 0x3004 gives 3 (data invalidate), 0x3005 gives 4 (data write-back), 0x3006 gives 5 (data lock), 0x2002 gives 6 (instruction prefetch), 0x2003 gives 7 (instruction invalidate), 0x2004 gives 8 (instruction lock). All of these registers except 0x3003 read as 0.
- R10: The data flush register 0x3003 reads 0 from reset and 0xFFFFFFFF once it has been written.
- R11: A TLB match entry (0x0800..0x080F) stores only bits [31:13] and bits [7:0]: valid, privilege, context and LRU. All other bits read as 0.
- R12: A TLB translate entry (0x0880..0x088F) stores only bits [31:13] and bits [9:0]: cache control and permissions. All other bits read as 0.
- R13: A write to an unmapped address changes nothing and raises no pulse. An unmapped address reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 16 | Write register address |
| wr_data | input | 32 | Write value |
| rd_addr | input | 16 | Read register address |
| rd_data | output | 32 | Combinational read result |
| cur_pc | input | 32 | Live program counter from the core |
| timer_cnt | input | 32 | Live timer count |
| pic_level_mode | input | 1 | 1 when the interrupt controller is level-triggered |
| gpr_rd_idx | output | 5 | GPR index for an aliased read |
| gpr_rd_data | input | 32 | GPR value for that index |
| gpr_wr | output | 1 | Aliased GPR write pulse |
| gpr_wr_idx | output | 5 | GPR index to write |
| gpr_wr_data | output | 32 | GPR value to write |
| pc_load | output | 1 | Redirect fetch and cancel delay slot |
| pc_load_val | output | 32 | New program counter |
| pc_next_fetch | output | 32 | Following fetch address |
| irq_en_pulse | output | 1 | Interrupt-enable notification |
| cmd_valid | output | 1 | Cache command pulse |
| cmd_op | output | 4 | Cache command code |
| cmd_addr | output | 32 | Cache command address |

## Verification
Most stored state can be seen at once on the combinational read port in the cycle after a write. A wrong filter mask, a lost forced status bit or a bad interrupt-status hold therefore shows on the first read-back. Errors in the side-effect path appear one cycle after the write edge: a missing or stretched pulse, a wrong command code, or an off-by-one fetch address. The interrupt-enable logic depends on the previous status value. For that reason it is driven through set, repeat-set and clear sequences, so that an edge detector that looks at the new value alone is exposed.

// File: rtl/spr_pkg.sv
package spr_pkg;
  localparam int DW = 32;
  localparam int AW = 16;

  localparam logic [AW-1:0] A_NPC    = 16'h0010;
  localparam logic [AW-1:0] A_STAT   = 16'h0011;
  localparam logic [AW-1:0] A_TIMER  = 16'h5001;
  localparam logic [AW-1:0] A_IMASK  = 16'h4800;
  localparam logic [AW-1:0] A_ISTAT  = 16'h4802;
  localparam logic [AW-1:0] A_DC_PF  = 16'h3002;
  localparam logic [AW-1:0] A_DC_FL  = 16'h3003;
  localparam logic [AW-1:0] A_DC_INV = 16'h3004;
  localparam logic [AW-1:0] A_DC_WB  = 16'h3005;
  localparam logic [AW-1:0] A_DC_LK  = 16'h3006;
  localparam logic [AW-1:0] A_IC_PF  = 16'h2002;
  localparam logic [AW-1:0] A_IC_INV = 16'h2003;
  localparam logic [AW-1:0] A_IC_LK  = 16'h2004;
  localparam logic [AW-1:0] A_GPR0   = 16'h0400;

  typedef enum logic [3:0] {
    CMD_NONE    = 4'd0,
    CMD_DC_PF   = 4'd1,
    CMD_DC_FL   = 4'd2,
    CMD_DC_INV  = 4'd3,
    CMD_DC_WB   = 4'd4,
    CMD_DC_LK   = 4'd5,
    CMD_IC_PF   = 4'd6,
    CMD_IC_INV  = 4'd7,
    CMD_IC_LK   = 4'd8
  } cache_cmd_e;
endpackage

// File: rtl/spr_tlb_store.sv
module spr_tlb_store #(
  parameter int          DW         = 32,
  parameter int          ENTRIES    = 16,
  parameter int          PAGE_LSB   = 13,
  parameter logic [31:0] MATCH_KEEP = 32'h0000_00FF,
  parameter logic [31:0] XLATE_KEEP = 32'h0000_03FF
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic                       we_xlate,
  input  logic [$clog2(ENTRIES)-1:0] we_idx,
  input  logic [DW-1:0]              wdata,
  input  logic                       rd_xlate,
  input  logic [$clog2(ENTRIES)-1:0] rd_idx,
  output logic [DW-1:0]              rdata
);
  localparam int          IW        = $clog2(ENTRIES);
  localparam logic [DW-1:0] PAGE_MASK = ~((DW'(1) << PAGE_LSB) - DW'(1));
  localparam logic [DW-1:0] M_KEEP    = PAGE_MASK | DW'(MATCH_KEEP);
  localparam logic [DW-1:0] X_KEEP    = PAGE_MASK | DW'(XLATE_KEEP);

  logic [DW-1:0] match_mem [ENTRIES];
  logic [DW-1:0] xlate_mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we && !we_xlate) match_mem[we_idx] <= wdata & M_KEEP;
    if (we &&  we_xlate) xlate_mem[we_idx] <= wdata & X_KEEP;
  end

  assign rdata = rd_xlate ? xlate_mem[rd_idx] : match_mem[rd_idx];

  logic [IW-1:0] last_idx;
  always_ff @(posedge clk) last_idx <= we_idx;

  assert_match_clean_R11: assert property (@(posedge clk) disable iff (rst)
    (we && !we_xlate) |=> ((match_mem[last_idx] & ~M_KEEP) == '0));
  assert_xlate_clean_R12: assert property (@(posedge clk) disable iff (rst)
    (we && we_xlate) |=> ((xlate_mem[last_idx] & ~X_KEEP) == '0));
endmodule

// File: rtl/spr_fx_pulse.sv
module spr_fx_pulse
  import spr_pkg::*;
#(
  parameter int DW  = 32,
  parameter int GIW = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic           sel_npc,
  input  logic           sel_gpr,
  input  logic [GIW-1:0] gpr_idx,
  input  cache_cmd_e     cmd_code,
  input  logic           irq_fire,
  input  logic [DW-1:0]  wr_data,
  output logic           gpr_wr,
  output logic [GIW-1:0] gpr_wr_idx,
  output logic [DW-1:0]  gpr_wr_data,
  output logic           pc_load,
  output logic [DW-1:0]  pc_load_val,
  output logic [DW-1:0]  pc_next_fetch,
  output logic           irq_en_pulse,
  output logic           cmd_valid,
  output logic [3:0]     cmd_op,
  output logic [DW-1:0]  cmd_addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      gpr_wr        <= 1'b0;
      gpr_wr_idx    <= '0;
      gpr_wr_data   <= '0;
      pc_load       <= 1'b0;
      pc_load_val   <= '0;
      pc_next_fetch <= '0;
      irq_en_pulse  <= 1'b0;
      cmd_valid     <= 1'b0;
      cmd_op        <= CMD_NONE;
      cmd_addr      <= '0;
    end else begin
      gpr_wr       <= wr_en && sel_gpr;
      pc_load      <= wr_en && sel_npc;
      irq_en_pulse <= irq_fire;
      cmd_valid    <= wr_en && (cmd_code != CMD_NONE);
      cmd_op       <= wr_en ? cmd_code : CMD_NONE;
      if (wr_en && sel_gpr) begin
        gpr_wr_idx  <= gpr_idx;
        gpr_wr_data <= wr_data;
      end
      if (wr_en && sel_npc) begin
        pc_load_val   <= wr_data;
        pc_next_fetch <= wr_data + DW'(4);
      end
      if (wr_en) cmd_addr <= wr_data;
    end
  end

  assert_pc_redirect_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel_npc) |=> (pc_load && pc_load_val == $past(wr_data)));
  assert_gpr_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel_gpr) |=> (gpr_wr && gpr_wr_idx == $past(gpr_idx)));
  assert_cmd_code_R9: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (cmd_op != CMD_NONE));
endmodule

// File: rtl/spr_access_unit.sv
module spr_access_unit
  import spr_pkg::*;
#(
  parameter int          TLB_ENTRIES = 16,
  parameter logic [15:0] TLB_BASE    = 16'h0800,
  parameter int          PAGE_LSB    = 13,
  parameter int          FO_BIT      = 15,
  parameter int          IEE_BIT     = 2,
  parameter logic [31:0] MATCH_KEEP  = 32'h0000_00FF,
  parameter logic [31:0] XLATE_KEEP  = 32'h0000_03FF
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [15:0] wr_addr,
  input  logic [31:0] wr_data,
  input  logic [15:0] rd_addr,
  output logic [31:0] rd_data,
  input  logic [31:0] cur_pc,
  input  logic [31:0] timer_cnt,
  input  logic        pic_level_mode,
  output logic [4:0]  gpr_rd_idx,
  input  logic [31:0] gpr_rd_data,
  output logic        gpr_wr,
  output logic [4:0]  gpr_wr_idx,
  output logic [31:0] gpr_wr_data,
  output logic        pc_load,
  output logic [31:0] pc_load_val,
  output logic [31:0] pc_next_fetch,
  output logic        irq_en_pulse,
  output logic        cmd_valid,
  output logic [3:0]  cmd_op,
  output logic [31:0] cmd_addr
);
  localparam int          IW       = $clog2(TLB_ENTRIES);
  localparam logic [31:0] STAT_RST = 32'(1) << FO_BIT;

  // write-side decode
  logic w_gpr, w_tlb, w_npc, w_stat, w_imask, w_istat, w_flush;
  assign w_gpr   = (wr_addr[15:5] == A_GPR0[15:5]);
  assign w_tlb   = (wr_addr[15:8] == TLB_BASE[15:8]) && (wr_addr[6:IW] == '0);
  assign w_npc   = (wr_addr == A_NPC);
  assign w_stat  = (wr_addr == A_STAT);
  assign w_imask = (wr_addr == A_IMASK);
  assign w_istat = (wr_addr == A_ISTAT);
  assign w_flush = (wr_addr == A_DC_FL);

  cache_cmd_e cmd_code;
  always_comb begin
    case (wr_addr)
      A_DC_PF:  cmd_code = CMD_DC_PF;
      A_DC_FL:  cmd_code = CMD_DC_FL;
      A_DC_INV: cmd_code = CMD_DC_INV;
      A_DC_WB:  cmd_code = CMD_DC_WB;
      A_DC_LK:  cmd_code = CMD_DC_LK;
      A_IC_PF:  cmd_code = CMD_IC_PF;
      A_IC_INV: cmd_code = CMD_IC_INV;
      A_IC_LK:  cmd_code = CMD_IC_LK;
      default:  cmd_code = CMD_NONE;
    endcase
  end

  // locally held registers
  logic [31:0] stat_q, imask_q, istat_q;
  logic        flushed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q    <= STAT_RST;
      imask_q   <= '0;
      istat_q   <= '0;
      flushed_q <= 1'b0;
    end else if (wr_en) begin
      if (w_stat)                    stat_q    <= wr_data | STAT_RST;
      if (w_imask)                   imask_q   <= wr_data;
      if (w_istat && !pic_level_mode) istat_q  <= wr_data;
      if (w_flush)                   flushed_q <= 1'b1;
    end
  end

  logic irq_fire;
  assign irq_fire = wr_en &&
    ((w_stat && wr_data[IEE_BIT] && !stat_q[IEE_BIT]) ||
     (w_imask && stat_q[IEE_BIT]));

  logic [31:0] tlb_rdata;
  spr_tlb_store #(
    .DW(32), .ENTRIES(TLB_ENTRIES), .PAGE_LSB(PAGE_LSB),
    .MATCH_KEEP(MATCH_KEEP), .XLATE_KEEP(XLATE_KEEP)
  ) u_tlb (
    .clk(clk), .rst(rst),
    .we(wr_en && w_tlb), .we_xlate(wr_addr[7]), .we_idx(wr_addr[IW-1:0]),
    .wdata(wr_data),
    .rd_xlate(rd_addr[7]), .rd_idx(rd_addr[IW-1:0]), .rdata(tlb_rdata)
  );

  spr_fx_pulse #(.DW(32), .GIW(5)) u_fx (
    .clk(clk), .rst(rst), .wr_en(wr_en),
    .sel_npc(w_npc), .sel_gpr(w_gpr), .gpr_idx(wr_addr[4:0]),
    .cmd_code(cmd_code), .irq_fire(irq_fire), .wr_data(wr_data),
    .gpr_wr(gpr_wr), .gpr_wr_idx(gpr_wr_idx), .gpr_wr_data(gpr_wr_data),
    .pc_load(pc_load), .pc_load_val(pc_load_val), .pc_next_fetch(pc_next_fetch),
    .irq_en_pulse(irq_en_pulse),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr)
  );

  // read side
  logic r_gpr, r_tlb;
  assign r_gpr      = (rd_addr[15:5] == A_GPR0[15:5]);
  assign r_tlb      = (rd_addr[15:8] == TLB_BASE[15:8]) && (rd_addr[6:IW] == '0);
  assign gpr_rd_idx = rd_addr[4:0];

  always_comb begin
    rd_data = '0;
    if (r_gpr)      rd_data = gpr_rd_data;
    else if (r_tlb) rd_data = tlb_rdata;
    else begin
      case (rd_addr)
        A_NPC:   rd_data = cur_pc;
        A_STAT:  rd_data = stat_q;
        A_TIMER: rd_data = timer_cnt;
        A_IMASK: rd_data = imask_q;
        A_ISTAT: rd_data = istat_q;
        A_DC_FL: rd_data = flushed_q ? '1 : '0;
        default: rd_data = '0;
      endcase
    end
  end

  assert_fo_forced_R5: assert property (@(posedge clk) disable iff (rst)
    stat_q[FO_BIT]);
  assert_istat_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && w_istat && pic_level_mode) |=> $stable(istat_q));
  assert_irq_edge_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && w_stat && wr_data[IEE_BIT] && !stat_q[IEE_BIT]) |=> irq_en_pulse);
  assert_irq_mask_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && w_imask && !stat_q[IEE_BIT] && !w_stat) |=> !irq_en_pulse);
endmodule

// File: tb/spr_access_unit_tb.sv
module spr_access_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [15:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic [31:0] cur_pc = '0;
  logic [31:0] timer_cnt = '0;
  logic        pic_level_mode = 1'b1;
  logic [4:0]  gpr_rd_idx;
  logic [31:0] gpr_rd_data = '0;
  logic        gpr_wr;
  logic [4:0]  gpr_wr_idx;
  logic [31:0] gpr_wr_data;
  logic        pc_load;
  logic [31:0] pc_load_val, pc_next_fetch;
  logic        irq_en_pulse;
  logic        cmd_valid;
  logic [3:0]  cmd_op;
  logic [31:0] cmd_addr;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  spr_access_unit u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cur_pc(cur_pc), .timer_cnt(timer_cnt),
    .pic_level_mode(pic_level_mode), .gpr_rd_idx(gpr_rd_idx),
    .gpr_rd_data(gpr_rd_data), .gpr_wr(gpr_wr), .gpr_wr_idx(gpr_wr_idx),
    .gpr_wr_data(gpr_wr_data), .pc_load(pc_load), .pc_load_val(pc_load_val),
    .pc_next_fetch(pc_next_fetch), .irq_en_pulse(irq_en_pulse),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr)
  );

  typedef struct packed {
    logic [15:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  // write then read back the same address
  localparam vec_t VECS [11] = '{
    '{16'h0011, 32'h0000_0001, 32'h0000_8001, 8'd5 },  // R5
    '{16'h0011, 32'h0000_0000, 32'h0000_8000, 8'd5 },  // R5
    '{16'h4800, 32'h1234_ABCD, 32'h1234_ABCD, 8'd7 },  // R7
    '{16'h0800, 32'hFFFF_FFFF, 32'hFFFF_E0FF, 8'd11},  // R11
    '{16'h0880, 32'hFFFF_FFFF, 32'hFFFF_E3FF, 8'd12},  // R12
    '{16'h0805, 32'h1234_5F3C, 32'h1234_403C, 8'd11},  // R11
    '{16'h088F, 32'hAAAA_5555, 32'hAAAA_4155, 8'd12},  // R12
    '{16'h3004, 32'hDEAD_0000, 32'h0000_0000, 8'd9 },  // R9
    '{16'h3003, 32'h0000_1000, 32'hFFFF_FFFF, 8'd10},  // R10
    '{16'h2004, 32'h0000_0005, 32'h0000_0000, 8'd9 },  // R9
    '{16'h7777, 32'h0000_0055, 32'h0000_0000, 8'd13}   // R13
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, take the edge, release at the next negedge
  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = 16'hFFF0; wr_data = '0;
  endtask

  task automatic rd(input logic [15:0] a);
    rd_addr = a;
    #1;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // reset state
    rd(16'h0011); chk("R5 reset status", rd_data, 32'h0000_8000);
    rd(16'h3003); chk("R10 flush reset", rd_data, 32'h0);
    rd(16'h4802); chk("R8 istat reset", rd_data, 32'h0);
    chk("R3 pc_load reset", 32'(pc_load), 32'h0);
    chk("R9 cmd_valid reset", 32'(cmd_valid), 32'h0);

    for (int i = 0; i < 11; i++) begin
      wr(VECS[i].addr, VECS[i].data);
      rd(VECS[i].addr);
      chk($sformatf("R%0d vector %0d", VECS[i].req, i), rd_data, VECS[i].exp);
      if (VECS[i].req == 8'd13) begin
        chk("R13 no cmd", 32'(cmd_valid), 32'h0);
        chk("R13 no gpr", 32'(gpr_wr), 32'h0);
        chk("R13 no pc", 32'(pc_load), 32'h0);
      end
    end

    // R3: NPC redirect
    cur_pc = 32'h0000_0100;
    wr(16'h0010, 32'h0000_2000);
    chk("R3 pc_load", 32'(pc_load), 32'h1);
    chk("R3 pc_load_val", pc_load_val, 32'h0000_2000);
    chk("R3 next fetch", pc_next_fetch, 32'h0000_2004);
    @(negedge clk);
    chk("R3 pulse one cycle", 32'(pc_load), 32'h0);
    // R4: live reads
    rd(16'h0010); chk("R4 npc reads cur_pc", rd_data, 32'h0000_0100);
    timer_cnt = 32'h0000_CAFE;
    rd(16'h5001); chk("R4 timer live", rd_data, 32'h0000_CAFE);

    // R1 / R2: GPR alias
    wr(16'h0407, 32'h0000_0077);
    chk("R2 gpr_wr", 32'(gpr_wr), 32'h1);
    chk("R2 gpr idx", 32'(gpr_wr_idx), 32'd7);
    chk("R2 gpr data", gpr_wr_data, 32'h77);
    @(negedge clk);
    chk("R2 gpr one cycle", 32'(gpr_wr), 32'h0);
    gpr_rd_data = 32'h0000_0099;
    rd(16'h041F);
    chk("R1 gpr rd idx", 32'(gpr_rd_idx), 32'd31);
    chk("R1 gpr rd data", rd_data, 32'h99);
    rd(16'h0420); chk("R1 past window", rd_data, 32'h0);
    wr(16'h0420, 32'h1);
    chk("R2 past window no write", 32'(gpr_wr), 32'h0);

    // R6 / R7: interrupt enable notifications
    wr(16'h4800, 32'h1);
    chk("R7 mask no pulse when disabled", 32'(irq_en_pulse), 32'h0);
    wr(16'h0011, 32'h4);
    chk("R6 rising enable pulse", 32'(irq_en_pulse), 32'h1);
    @(negedge clk);
    chk("R6 pulse one cycle", 32'(irq_en_pulse), 32'h0);
    wr(16'h0011, 32'h4);
    chk("R6 already enabled", 32'(irq_en_pulse), 32'h0);
    wr(16'h4800, 32'h3);
    chk("R7 mask pulse when enabled", 32'(irq_en_pulse), 32'h1);
    rd(16'h4800); chk("R7 mask stored", rd_data, 32'h3);
    wr(16'h0011, 32'h0);
    wr(16'h4800, 32'h5);
    chk("R7 mask after disable", 32'(irq_en_pulse), 32'h0);

    // R8: interrupt status filtering
    pic_level_mode = 1'b1;
    wr(16'h4802, 32'hF);
    rd(16'h4802); chk("R8 level discards", rd_data, 32'h0);
    pic_level_mode = 1'b0;
    wr(16'h4802, 32'hF);
    rd(16'h4802); chk("R8 edge stores", rd_data, 32'hF);
    pic_level_mode = 1'b1;
    wr(16'h4802, 32'h3);
    rd(16'h4802); chk("R8 level keeps old", rd_data, 32'hF);

    // R9: command pulses
    wr(16'h3002, 32'h0000_0400);
    chk("R9 cmd_valid", 32'(cmd_valid), 32'h1);
    chk("R9 cmd_op dc prefetch", 32'(cmd_op), 32'd1);
    chk("R9 cmd_addr", cmd_addr, 32'h400);
    @(negedge clk);
    chk("R9 one cycle", 32'(cmd_valid), 32'h0);
    wr(16'h2003, 32'h0000_0800);
    chk("R9 cmd_op ic invalidate", 32'(cmd_op), 32'd7);
    wr(16'h3005, 32'h0000_0C00);
    chk("R9 cmd_op dc write-back", 32'(cmd_op), 32'd4);
    rd(16'h3005); chk("R9 reads zero", rd_data, 32'h0);

    // R10: flush survives other writes
    rd(16'h3003); chk("R10 flush ones", rd_data, 32'hFFFF_FFFF);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule